// File: doc/BRIEF.md
# Envelope-Ripple Coefficient Adapter

This block tunes the four correction coefficients of an I/Q precompensation stage so that the envelope of the synthesizer output becomes flat. It receives envelope samples from an A/D converter together with a pulse that marks each NCO-cycle boundary. Over each cycle it tracks the highest and lowest envelope sample. At the boundary it takes their difference, the ripple, as the error to minimise.

Each accepted cycle adjusts exactly one coefficient, in a fixed rotation. The sign of the step comes from that coefficient's own ripple history: if the ripple grew since the coefficient was last adjusted, the direction flips. The size of the step is lam1*ripple/(lam2+ripple), which saturates toward lam1 but never reaches it. A sequential restoring divider computes the step. The coefficient registers clamp at their fixed-point limits.

The controller has three states. COLLECT waits for a boundary. The transition COLLECT->DIVIDE fires on a boundary that closes a cycle with enough samples. DIVIDE->APPLY fires on the divider's final step. APPLY->COLLECT is unconditional after one clock. Coefficients are signed 16-bit with 1.0 = 16384. Envelope samples are 12-bit unsigned with 1.0 = 2048.

Top module: `ripple_coef_adapter`

## Requirements
- R1: After reset, k_cross = 0, k_scale = 16384, k_off_i = 0, k_off_q = 0 and upd_strobe = 0.
- R2: The ripple of a cycle is the largest minus the smallest valid sample since the previous boundary. A sample that is valid in the same clock as the boundary belongs to the new cycle.
- R3: A cycle that closes with fewer than 4 valid samples changes no coefficient, and the rotation does not advance.
- R4: Each accepted cycle adapts exactly one coefficient. The rotation runs k_cross, k_scale, k_off_i, k_off_q and then back to k_cross.
- R5: The step is floor(L1*d/(L2+d)), where d is the ripple. k_cross and k_scale use L1 = 328 and L2 = 82. k_off_i and k_off_q use L1 = 33 and L2 = 20. The step is always below L1, and a ripple of zero gives a step of zero.
- R6: Every coefficient starts with a positive direction. At each adaptation its direction flips when the new ripple is greater than the ripple recorded at its previous adaptation, and is kept otherwise. The first adaptation of a coefficient never flips.
- R7: The adapted coefficient takes its new value 29 clocks after the clock in which the boundary is sampled. A boundary sampled during those 29 clocks, the 29th included, is ignored for adaptation, but it still restarts the ripple measurement.
- R8: Coefficients saturate at 32767 and at -32768.
- R9: upd_strobe is high for exactly the one clock in which a coefficient takes a new, different value. It stays low when an update leaves the value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| env_vld | input | 1 | Envelope sample valid |
| env_smp | input | 12 | Unsigned envelope sample |
| cyc_mark | input | 1 | NCO-cycle boundary pulse |
| k_cross | output | 16 | Quadrature cross-coupling coefficient (signed) |
| k_scale | output | 16 | Quadrature gain coefficient (signed) |
| k_off_i | output | 16 | I offset coefficient (signed) |
| k_off_q | output | 16 | Q offset coefficient (signed) |
| upd_strobe | output | 1 | One-clock pulse on a coefficient change |

## Verification
The assertions take for granted that the boundary pulse lasts one clock and that the sample inputs are known whenever env_vld is high. They also rely on the divisor never being zero, which holds because lam2 is a positive constant. The stimulus holds env_vld low in the clock of every boundary except one deliberate case, which exercises the rule that such a sample opens the new cycle. One boundary is placed only 11 clocks after an accepted one to exercise the skip path. Every other boundary follows 33 clocks after the previous one, which is longer than the 29-clock adaptation time.

// File: rtl/rca_pkg.sv
package rca_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_DIVIDE  = 2'd1,
        ST_APPLY   = 2'd2
    } adapt_state_e;

    localparam int NUM_COEF = 4;
    localparam int SEL_W    = $clog2(NUM_COEF);
endpackage

// File: rtl/env_span_tracker.sv
module env_span_tracker #(
    parameter int ENV_W   = 12,
    parameter int MIN_SMP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [ENV_W-1:0] smp,
    input  logic             restart,
    output logic [ENV_W-1:0] span,
    output logic             enough
);
    localparam int CNT_W = $clog2(MIN_SMP + 1);

    logic [ENV_W-1:0] hi_q, lo_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '1;
            cnt_q <= '0;
        end else if (restart) begin
            if (smp_vld) begin
                hi_q  <= smp;
                lo_q  <= smp;
                cnt_q <= CNT_W'(1);
            end else begin
                hi_q  <= '0;
                lo_q  <= '1;
                cnt_q <= '0;
            end
        end else if (smp_vld) begin
            if (smp > hi_q) hi_q <= smp;
            if (smp < lo_q) lo_q <= smp;
            if (cnt_q < CNT_W'(MIN_SMP)) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign span   = (cnt_q != '0) ? (hi_q - lo_q) : '0;
    assign enough = (cnt_q >= CNT_W'(MIN_SMP));

    // R2
    span_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (hi_q >= lo_q));
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
    parameter int NUM_W = 28,
    parameter int DEN_W = 13,
    parameter int Q_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [Q_W-1:0]   quo,
    output logic             last
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q, den_q;
    logic [NUM_W-1:0] q_q;
    logic [CW-1:0]    cnt_q;
    logic [DEN_W:0]   trial, diff;
    logic             ge;

    always_comb begin
        trial = {rem_q, q_q[NUM_W-1]};
        ge    = (trial >= {1'b0, den_q});
        diff  = trial - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '1;
            q_q   <= '0;
            cnt_q <= '0;
        end else if (start) begin
            rem_q <= '0;
            den_q <= den;
            q_q   <= num;
            cnt_q <= CW'(NUM_W);
        end else if (cnt_q != '0) begin
            rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            q_q   <= {q_q[NUM_W-2:0], ge};
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign quo  = q_q[Q_W-1:0];
    assign last = (cnt_q == CW'(1));

    // R5
    div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (rem_q < den_q));
endmodule

// File: rtl/coef_bank.sv
module coef_bank
    import rca_pkg::*;
#(
    parameter int COEF_W     = 16,
    parameter int SCALE_INIT = 16384
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             apply,
    input  logic [SEL_W-1:0]                 sel,
    input  logic [COEF_W-1:0]                step,
    input  logic                             neg,
    output logic [NUM_COEF-1:0][COEF_W-1:0]  coef_o,
    output logic                             changed
);
    localparam logic signed [COEF_W:0] SMAX = (COEF_W+1)'((1 << (COEF_W-1)) - 1);
    localparam logic signed [COEF_W:0] SMIN = -SMAX - (COEF_W+1)'(1);

    logic signed [COEF_W:0]   cur_x, step_x, sum;
    logic        [COEF_W-1:0] nxt;

    always_comb begin
        cur_x  = {coef_o[sel][COEF_W-1], coef_o[sel]};
        step_x = {1'b0, step};
        sum    = neg ? (cur_x - step_x) : (cur_x + step_x);
        if (sum > SMAX)      nxt = SMAX[COEF_W-1:0];
        else if (sum < SMIN) nxt = SMIN[COEF_W-1:0];
        else                 nxt = sum[COEF_W-1:0];
    end

    for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
        localparam logic [COEF_W-1:0] RST_V = (i == 1) ? COEF_W'(SCALE_INIT) : '0;
        logic [COEF_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                             val_q <= RST_V;
            else if (apply && (sel == SEL_W'(i)))   val_q <= nxt;
        end
        assign coef_o[i] = val_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) changed <= 1'b0;
        else        changed <= apply && (nxt != coef_o[sel]);
    end

    // R4
    one_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({coef_o[0] != $past(coef_o[0]), coef_o[1] != $past(coef_o[1]),
                    coef_o[2] != $past(coef_o[2]), coef_o[3] != $past(coef_o[3])}) <= 1);
endmodule

// File: rtl/ripple_coef_adapter.sv
module ripple_coef_adapter
    import rca_pkg::*;
#(
    parameter int ENV_W      = 12,
    parameter int COEF_W     = 16,
    parameter int MIN_SMP    = 4,
    parameter int L1_GAIN    = 328,
    parameter int L2_GAIN    = 82,
    parameter int L1_OFS     = 33,
    parameter int L2_OFS     = 20,
    parameter int SCALE_INIT = 16384
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     env_vld,
    input  logic [ENV_W-1:0]         env_smp,
    input  logic                     cyc_mark,
    output logic signed [COEF_W-1:0] k_cross,
    output logic signed [COEF_W-1:0] k_scale,
    output logic signed [COEF_W-1:0] k_off_i,
    output logic signed [COEF_W-1:0] k_off_q,
    output logic                     upd_strobe
);
    localparam int NUM_W = ENV_W + COEF_W;
    localparam int DEN_W = ENV_W + 1;

    adapt_state_e state_q, state_d;

    logic [ENV_W-1:0]  span;
    logic              enough, accept, div_last, reverse, neg_new, is_gain;
    logic [SEL_W-1:0]  ptr_q, sel_q;
    logic [NUM_COEF-1:0] neg_q;
    logic [ENV_W-1:0]  prev_q [NUM_COEF];
    logic [COEF_W-1:0] lam1, lam1_q, step;
    logic [ENV_W-1:0]  lam2;
    logic [NUM_W-1:0]  num;
    logic [DEN_W-1:0]  den;
    logic [NUM_COEF-1:0][COEF_W-1:0] coef_vec;

    env_span_tracker #(.ENV_W(ENV_W), .MIN_SMP(MIN_SMP)) u_track (
        .clk(clk), .rst_n(rst_n), .smp_vld(env_vld), .smp(env_smp),
        .restart(cyc_mark), .span(span), .enough(enough)
    );

    always_comb begin
        accept  = cyc_mark && (state_q == ST_COLLECT) && enough;
        is_gain = (ptr_q < SEL_W'(2));
        lam1    = is_gain ? COEF_W'(L1_GAIN) : COEF_W'(L1_OFS);
        lam2    = is_gain ? ENV_W'(L2_GAIN)  : ENV_W'(L2_OFS);
        num     = NUM_W'(lam1) * NUM_W'(span);
        den     = DEN_W'(lam2) + DEN_W'(span);
        reverse = (span > prev_q[ptr_q]);
        neg_new = neg_q[ptr_q] ^ reverse;
    end

    restoring_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(COEF_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(accept), .num(num), .den(den),
        .quo(step), .last(div_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (accept)   state_d = ST_DIVIDE;
            ST_DIVIDE:  if (div_last) state_d = ST_APPLY;
            ST_APPLY:                 state_d = ST_COLLECT;
            default:                  state_d = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            sel_q  <= '0;
            neg_q  <= '0;
            lam1_q <= '0;
            for (int i = 0; i < NUM_COEF; i++) prev_q[i] <= '1;
        end else if (accept) begin
            sel_q         <= ptr_q;
            ptr_q         <= ptr_q + SEL_W'(1);
            neg_q[ptr_q]  <= neg_new;
            prev_q[ptr_q] <= span;
            lam1_q        <= lam1;
        end
    end

    coef_bank #(.COEF_W(COEF_W), .SCALE_INIT(SCALE_INIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .apply(state_q == ST_APPLY), .sel(sel_q),
        .step(step), .neg(neg_q[sel_q]), .coef_o(coef_vec), .changed(upd_strobe)
    );

    assign k_cross = coef_vec[0];
    assign k_scale = coef_vec[1];
    assign k_off_i = coef_vec[2];
    assign k_off_q = coef_vec[3];

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |=> !upd_strobe);
    // R9
    strobe_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |-> (coef_vec != $past(coef_vec)));
    // R5
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY) |-> (step < lam1_q));
    // R7
    busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_mark && state_q != ST_COLLECT) |=> $stable(ptr_q));
endmodule

// File: tb/ripple_coef_adapter_tb.sv
`timescale 1ns/1ps
module ripple_coef_adapter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic env_vld = 1'b0;
    logic [11:0] env_smp = '0;
    logic cyc_mark = 1'b0;
    logic signed [15:0] k_cross, k_scale, k_off_i, k_off_q;
    logic upd_strobe;

    int n_chk = 0;
    int n_fail = 0;
    int strobe_cnt = 0;

    always #2.5 clk = ~clk;

    ripple_coef_adapter u_dut (
        .clk(clk), .rst_n(rst_n), .env_vld(env_vld), .env_smp(env_smp),
        .cyc_mark(cyc_mark), .k_cross(k_cross), .k_scale(k_scale),
        .k_off_i(k_off_i), .k_off_q(k_off_q), .upd_strobe(upd_strobe)
    );

    // behavioural reference
    int m_coef[4];
    int m_neg[4];
    int m_prev[4];
    int m_ptr, m_pend, m_val, m_sel, m_mx, m_mn, m_cnt;
    bit m_strobe;

    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_coef = '{0, 16384, 0, 0};
            m_neg = '{0, 0, 0, 0};
            m_prev = '{4095, 4095, 4095, 4095};
            m_ptr = 0; m_pend = 0; m_strobe = 0;
            m_mx = 0; m_mn = 4095; m_cnt = 0;
        end else begin
            bit busy;
            busy = (m_pend > 0);
            m_strobe = 0;
            if (m_pend > 0) begin
                m_pend--;
                if (m_pend == 0) begin
                    m_strobe = (m_val != m_coef[m_sel]);
                    m_coef[m_sel] = m_val;
                end
            end
            if (cyc_mark) begin
                if (!busy && m_cnt >= 4) begin
                    int d, l1, l2, st;
                    d = m_mx - m_mn;
                    if (d > m_prev[m_ptr]) m_neg[m_ptr] = 1 - m_neg[m_ptr];
                    m_prev[m_ptr] = d;
                    l1 = (m_ptr < 2) ? 328 : 33;
                    l2 = (m_ptr < 2) ? 82 : 20;
                    st = (l1 * d) / (l2 + d);
                    m_val = sat16(m_neg[m_ptr] ? m_coef[m_ptr] - st : m_coef[m_ptr] + st);
                    m_sel = m_ptr;
                    m_ptr = (m_ptr + 1) % 4;
                    m_pend = 29;
                end
                m_cnt = 0; m_mx = 0; m_mn = 4095;
            end
            if (env_vld) begin
                if (int'(env_smp) > m_mx) m_mx = int'(env_smp);
                if (int'(env_smp) < m_mn) m_mn = int'(env_smp);
                m_cnt++;
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(k_cross) == m_coef[0], "R4 R5 R6 R7 R8 k_cross", int'(k_cross), m_coef[0]);
            check(int'(k_scale) == m_coef[1], "R4 R5 R6 R7 R8 k_scale", int'(k_scale), m_coef[1]);
            check(int'(k_off_i) == m_coef[2], "R4 R5 R6 R7 R8 k_off_i", int'(k_off_i), m_coef[2]);
            check(int'(k_off_q) == m_coef[3], "R4 R5 R6 R7 R8 k_off_q", int'(k_off_q), m_coef[3]);
            check(upd_strobe == m_strobe, "R9 strobe", int'(upd_strobe), int'(m_strobe));
            if (upd_strobe) strobe_cnt++;
        end
    end

    task automatic nco_cycle(int lo, int hi, int n, int len, int mark_smp);
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            cyc_mark = 1'b0;
            env_vld = (c < n);
            env_smp = 12'((c == 0) ? lo : (c == 1) ? hi : (lo + hi) / 2);
        end
        @(negedge clk);
        cyc_mark = 1'b1;
        env_vld = (mark_smp >= 0);
        env_smp = 12'((mark_smp >= 0) ? mark_smp : 0);
    endtask

    task automatic idle(int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            cyc_mark = 1'b0;
            env_vld = 1'b0;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(k_cross == 0, "R1 k_cross", int'(k_cross), 0);
        check(k_scale == 16384, "R1 k_scale", int'(k_scale), 16384);
        check(k_off_i == 0 && k_off_q == 0, "R1 offsets", int'(k_off_i), 0);
        check(!upd_strobe, "R1 strobe", int'(upd_strobe), 0);

        // R2 R4 R5: one full rotation with ripple 400
        for (int k = 0; k < 4; k++) nco_cycle(1000, 1400, 8, 32, -1);
        idle(35);
        check(k_cross == 272, "R5 k_cross step", int'(k_cross), 272);
        check(k_scale == 16656, "R4 k_scale step", int'(k_scale), 16656);
        check(k_off_i == 31, "R5 k_off_i step", int'(k_off_i), 31);
        check(strobe_cnt == 4, "R9 strobe count", strobe_cnt, 4);

        // R3: too few samples, no update and no rotation
        nco_cycle(0, 3000, 3, 32, -1);
        idle(35);
        check(k_cross == 272 && k_scale == 16656, "R3 no update", int'(k_cross), 272);

        // R6: larger ripple reverses k_cross
        nco_cycle(1000, 1600, 8, 32, -1);
        idle(35);
        check(k_cross == -16, "R6 reversal", int'(k_cross), -16);

        // R7: boundary while busy is skipped
        nco_cycle(1000, 1500, 8, 32, -1);
        nco_cycle(1000, 1100, 8, 10, -1);
        idle(40);
        check(k_off_i == 31, "R7 skipped boundary", int'(k_off_i), 31);

        // R2: sample on the boundary opens the new cycle
        nco_cycle(2000, 2100, 8, 32, 4000);
        nco_cycle(2000, 2050, 6, 32, -1);
        // R5: zero ripple
        nco_cycle(2000, 2000, 8, 32, -1);
        idle(35);

        // R8: long run with constant ripple drives the gain pair into saturation
        for (int k = 0; k < 640; k++) nco_cycle(0, 4000, 8, 32, -1);
        idle(35);
        check(k_scale == 32767 || k_scale == -32768, "R8 k_scale saturated", int'(k_scale), 32767);
        check(k_cross == 32767 || k_cross == -32768, "R8 k_cross saturated", int'(k_cross), 32767);
        summary();
    end
endmodule